// File: doc/BRIEF.md
# Address-Space-Aware L1 Cache Controller

This block controls a small on-chip memory that serves two roles at once: a scratchpad and a direct-mapped data cache. Every request carries a two-bit space tag, a store flag, a byte address and a data word. The policy applied to the request depends on the tag.

Scratchpad (shared) requests go straight to the scratchpad array. They never look at the tags. Local requests are cached with write-back and write-allocate; a dirty victim is written out before the refill. Global requests are never cached. They always go to the next memory level, and a line they match is invalidated. Read-only loads are passed through unchanged on a separate output port and get no response from this block.

Next-level traffic moves in 128-byte lines. A transfer carries the line address (request address bits [ADDR_W-1:7]), a full line of data and a per-word write mask. Only one miss or bypass is in flight at a time.

Top module: `l1_space_ctrl`

## Requirements
- R1: A shared request (space code 0) with a byte address below SPAD_WORDS*4 reads or writes scratchpad word address>>2. Its response comes on the cycle after acceptance, and it causes no next-level traffic. A store response carries data 0.
- R2: A shared request never changes the valid state of any cache line. A line that hit before a shared access still hits after it.
- R3: A shared request at or above SPAD_WORDS*4 returns rsp_err_o=1 with data 0 on the cycle after acceptance.
- R4: A local request (space code 1) looks up the direct-mapped tags; index is address bits [9:7] and word is bits [6:2] for 8 lines of 32-bit words. A miss fetches the line with one next-level read of address[31:7] and then responds. A hit responds on the next cycle with no next-level traffic.
- R5: A local store hit marks the line dirty. Evicting a dirty line issues one next-level write with an all-ones word mask carrying the whole victim line, before the refill read.
- R6: A global request (space code 2) is always forwarded as one next-level transfer and never allocates a line. A store sets only mask bit address[6:2] and puts its data in that word slot. A load returns word address[6:2] of the returned line.
- R7: A global request that matches a valid line invalidates that line without writing it back. A later local access to the line misses.
- R8: A read-only load (space code 3, store flag 0) raises ro_valid_o with ro_addr_o equal to the request address in the same cycle. It produces neither a response nor next-level traffic. A store with space code 3 returns an error response.
- R9: req_ready_o falls on the cycle after a miss or global request is accepted and stays low until the cycle after nl_rsp_valid_i. rsp_valid_o rises on that same cycle.
- R10: During and after reset, req_ready_o is 1, rsp_valid_o and nl_req_valid_o are 0, and all lines are invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller can accept a request |
| req_space_i | input | 2 | Space: 0 shared, 1 local, 2 global, 3 read-only |
| req_we_i | input | 1 | 1 for store, 0 for load |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | DATA_W | Store data |
| rsp_valid_o | output | 1 | Response valid |
| rsp_err_o | output | 1 | Response is an error |
| rsp_rdata_o | output | DATA_W | Load data, 0 for stores and errors |
| ro_valid_o | output | 1 | Read-only load forwarded |
| ro_addr_o | output | ADDR_W | Forwarded read-only address |
| nl_req_valid_o | output | 1 | Next-level request, one-cycle pulse |
| nl_req_we_o | output | 1 | Next-level write |
| nl_req_line_o | output | ADDR_W-7 | Next-level line address |
| nl_req_wmask_o | output | 128*8/DATA_W | Per-word write mask |
| nl_req_wdata_o | output | 1024 | Line write data |
| nl_rsp_valid_i | input | 1 | Next-level response, one per request |
| nl_rsp_rdata_i | input | 1024 | Line read data |

## Verification
The assertions check several properties on every cycle. Shared accesses leave the valid vector untouched. Out-of-range shared accesses produce an error response. A global hit clears its line's valid bit, and the bypass wait allocates nothing. Ready is low whenever a next-level request is issued, a next-level response leads to a requester response, and read-only loads get no response. Other behaviours show only in the bench scenarios, which compare data and next-level traffic against a model: dirty data reaching memory on eviction, dirty data being discarded by a global invalidate, global accesses going out again after a global hit, and single-word store masks.

// File: rtl/l1_pkg.sv
package l1_pkg;
  localparam int unsigned LINE_OFF_W = 7;
  localparam int unsigned LINE_BITS  = 1024;

  typedef enum logic [1:0] {
    SP_SHARED = 2'd0,
    SP_LOCAL  = 2'd1,
    SP_GLOBAL = 2'd2,
    SP_RDONLY = 2'd3
  } space_e;

  typedef enum logic [2:0] {
    S_IDLE, S_WB, S_WB_W, S_FILL, S_FILL_W, S_BYP, S_BYP_W
  } ctrl_state_e;
endpackage

// File: rtl/l1_tag_store.sv
module l1_tag_store #(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned TAG_W     = 22,
  localparam int unsigned IDX_W    = $clog2(NUM_LINES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic [TAG_W-1:0]     tag_i,
  output logic                 hit_o,
  output logic                 vic_dirty_o,
  output logic [TAG_W-1:0]     vic_tag_o,
  input  logic                 inval_i,
  input  logic                 alloc_i,
  input  logic                 alloc_dirty_i,
  input  logic [TAG_W-1:0]     alloc_tag_i,
  input  logic                 set_dirty_i,
  output logic [NUM_LINES-1:0] valid_o
);
  logic [NUM_LINES-1:0] valid_q, dirty_q;
  logic [TAG_W-1:0]     tag_q [NUM_LINES];

  assign hit_o       = valid_q[idx_i] && (tag_q[idx_i] == tag_i);
  assign vic_dirty_o = valid_q[idx_i] && dirty_q[idx_i];
  assign vic_tag_o   = tag_q[idx_i];
  assign valid_o     = valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
      for (int i = 0; i < NUM_LINES; i++) tag_q[i] <= '0;
    end else if (inval_i) begin
      valid_q[idx_i] <= 1'b0;
      dirty_q[idx_i] <= 1'b0;
    end else if (alloc_i) begin
      valid_q[idx_i] <= 1'b1;
      dirty_q[idx_i] <= alloc_dirty_i;
      tag_q[idx_i]   <= alloc_tag_i;
    end else if (set_dirty_i) begin
      dirty_q[idx_i] <= 1'b1;
    end
  end

  assert_one_update_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({inval_i, alloc_i, set_dirty_i}));
endmodule

// File: rtl/l1_line_store.sv
module l1_line_store #(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned LINE_W    = 1024,
  parameter int unsigned DATA_W    = 32,
  localparam int unsigned IDX_W    = $clog2(NUM_LINES),
  localparam int unsigned WSEL_W   = $clog2(LINE_W / DATA_W)
) (
  input  logic              clk_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [LINE_W-1:0] rd_line_o,
  input  logic              wr_word_i,
  input  logic [WSEL_W-1:0] wsel_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_line_i,
  input  logic [LINE_W-1:0] wline_i
);
  logic [LINE_W-1:0] line_q [NUM_LINES];

  assign rd_line_o = line_q[idx_i];

  always_ff @(posedge clk_i) begin
    if (wr_line_i)      line_q[idx_i] <= wline_i;
    else if (wr_word_i) line_q[idx_i][wsel_i*DATA_W +: DATA_W] <= wdata_i;
  end
endmodule

// File: rtl/l1_spad_mem.sv
module l1_spad_mem #(
  parameter int unsigned WORDS  = 64,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [WORDS];

  assign rdata_o = mem_q[idx_i];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[idx_i] <= wdata_i;
  end
endmodule

// File: rtl/l1_space_ctrl.sv
module l1_space_ctrl import l1_pkg::*; #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned NUM_LINES  = 8,
  parameter int unsigned SPAD_WORDS = 64,
  localparam int unsigned LINE_W    = LINE_BITS,
  localparam int unsigned WB_LSB    = $clog2(DATA_W / 8),
  localparam int unsigned LWORDS    = LINE_W / DATA_W,
  localparam int unsigned WSEL_W    = $clog2(LWORDS),
  localparam int unsigned IDX_W     = $clog2(NUM_LINES),
  localparam int unsigned LADDR_W   = ADDR_W - LINE_OFF_W,
  localparam int unsigned TAG_W     = LADDR_W - IDX_W,
  localparam int unsigned SP_IDX_W  = $clog2(SPAD_WORDS),
  localparam int unsigned SPAD_BYTES = SPAD_WORDS * (DATA_W / 8)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [1:0]         req_space_i,
  input  logic               req_we_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [DATA_W-1:0]  req_wdata_i,
  output logic               rsp_valid_o,
  output logic               rsp_err_o,
  output logic [DATA_W-1:0]  rsp_rdata_o,
  output logic               ro_valid_o,
  output logic [ADDR_W-1:0]  ro_addr_o,
  output logic               nl_req_valid_o,
  output logic               nl_req_we_o,
  output logic [LADDR_W-1:0] nl_req_line_o,
  output logic [LWORDS-1:0]  nl_req_wmask_o,
  output logic [LINE_W-1:0]  nl_req_wdata_o,
  input  logic               nl_rsp_valid_i,
  input  logic [LINE_W-1:0]  nl_rsp_rdata_i
);
  ctrl_state_e state_q, state_d;
  space_e      space;
  logic        accept, in_range, hit, vic_dirty;
  logic [TAG_W-1:0]  vic_tag;
  logic [IDX_W-1:0]  idx_in, lk_idx;
  logic [TAG_W-1:0]  tag_in;
  logic [WSEL_W-1:0] wsel_in;
  logic [NUM_LINES-1:0] valid_vec;
  logic [LINE_W-1:0] rd_line, fill_line;
  logic [DATA_W-1:0] spad_rdata, rd_word, rsp_word;

  // saved request for miss / bypass
  logic              sv_we;
  logic [LADDR_W-1:0] sv_line;
  logic [WSEL_W-1:0] sv_wsel;
  logic [DATA_W-1:0] sv_wdata;
  logic              save;

  logic              rsp_v_d, rsp_e_d;
  logic [DATA_W-1:0] rsp_d_d;
  logic spad_we, wr_word, wr_line, alloc, set_dirty, inval;

  assign space    = space_e'(req_space_i);
  assign accept   = req_valid_i && (state_q == S_IDLE);
  assign in_range = req_addr_i < ADDR_W'(SPAD_BYTES);
  assign idx_in   = req_addr_i[LINE_OFF_W +: IDX_W];
  assign tag_in   = req_addr_i[ADDR_W-1 -: TAG_W];
  assign wsel_in  = req_addr_i[WB_LSB +: WSEL_W];
  assign lk_idx   = (state_q == S_IDLE) ? idx_in : sv_line[IDX_W-1:0];
  assign rd_word  = rd_line[wsel_in*DATA_W +: DATA_W];
  assign rsp_word = nl_rsp_rdata_i[sv_wsel*DATA_W +: DATA_W];

  assign req_ready_o = (state_q == S_IDLE);
  assign ro_valid_o  = accept && (space == SP_RDONLY) && !req_we_i;
  assign ro_addr_o   = req_addr_i;

  always_comb begin
    fill_line = nl_rsp_rdata_i;
    if (sv_we) fill_line[sv_wsel*DATA_W +: DATA_W] = sv_wdata;
  end

  always_comb begin
    state_d = state_q;
    rsp_v_d = 1'b0; rsp_e_d = 1'b0; rsp_d_d = '0;
    spad_we = 1'b0; wr_word = 1'b0; wr_line = 1'b0;
    alloc = 1'b0; set_dirty = 1'b0; inval = 1'b0; save = 1'b0;
    nl_req_valid_o = 1'b0; nl_req_we_o = 1'b0; nl_req_line_o = sv_line;
    nl_req_wmask_o = '0; nl_req_wdata_o = '0;
    unique case (state_q)
      S_IDLE: if (req_valid_i) begin
        unique case (space)
          SP_SHARED: begin
            rsp_v_d = 1'b1;
            if (in_range) begin
              spad_we = req_we_i;
              rsp_d_d = req_we_i ? '0 : spad_rdata;
            end else rsp_e_d = 1'b1;
          end
          SP_LOCAL: begin
            if (hit) begin
              rsp_v_d   = 1'b1;
              wr_word   = req_we_i;
              set_dirty = req_we_i;
              rsp_d_d   = req_we_i ? '0 : rd_word;
            end else begin
              save    = 1'b1;
              state_d = vic_dirty ? S_WB : S_FILL;
            end
          end
          SP_GLOBAL: begin
            save    = 1'b1;
            inval   = hit;
            state_d = S_BYP;
          end
          SP_RDONLY: begin
            rsp_v_d = req_we_i;
            rsp_e_d = req_we_i;
          end
          default: ;
        endcase
      end
      S_WB: begin
        nl_req_valid_o = 1'b1;
        nl_req_we_o    = 1'b1;
        nl_req_line_o  = {vic_tag, sv_line[IDX_W-1:0]};
        nl_req_wmask_o = '1;
        nl_req_wdata_o = rd_line;
        state_d        = S_WB_W;
      end
      S_WB_W: if (nl_rsp_valid_i) state_d = S_FILL;
      S_FILL: begin
        nl_req_valid_o = 1'b1;
        state_d        = S_FILL_W;
      end
      S_FILL_W: if (nl_rsp_valid_i) begin
        wr_line = 1'b1;
        alloc   = 1'b1;
        rsp_v_d = 1'b1;
        rsp_d_d = sv_we ? '0 : rsp_word;
        state_d = S_IDLE;
      end
      S_BYP: begin
        nl_req_valid_o = 1'b1;
        nl_req_we_o    = sv_we;
        if (sv_we) begin
          nl_req_wmask_o[sv_wsel] = 1'b1;
          nl_req_wdata_o[sv_wsel*DATA_W +: DATA_W] = sv_wdata;
        end
        state_d = S_BYP_W;
      end
      S_BYP_W: if (nl_rsp_valid_i) begin
        rsp_v_d = 1'b1;
        rsp_d_d = sv_we ? '0 : rsp_word;
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      rsp_valid_o <= 1'b0;
      rsp_err_o   <= 1'b0;
      rsp_rdata_o <= '0;
      sv_we       <= 1'b0;
      sv_line     <= '0;
      sv_wsel     <= '0;
      sv_wdata    <= '0;
    end else begin
      state_q     <= state_d;
      rsp_valid_o <= rsp_v_d;
      rsp_err_o   <= rsp_e_d;
      rsp_rdata_o <= rsp_d_d;
      if (save) begin
        sv_we    <= req_we_i;
        sv_line  <= req_addr_i[ADDR_W-1:LINE_OFF_W];
        sv_wsel  <= wsel_in;
        sv_wdata <= req_wdata_i;
      end
    end
  end

  l1_tag_store #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W)) u_tags (
    .clk_i, .rst_ni, .idx_i(lk_idx), .tag_i(tag_in), .hit_o(hit),
    .vic_dirty_o(vic_dirty), .vic_tag_o(vic_tag), .inval_i(inval),
    .alloc_i(alloc), .alloc_dirty_i(sv_we), .alloc_tag_i(sv_line[LADDR_W-1:IDX_W]),
    .set_dirty_i(set_dirty), .valid_o(valid_vec));

  l1_line_store #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W), .DATA_W(DATA_W)) u_lines (
    .clk_i, .idx_i(lk_idx), .rd_line_o(rd_line), .wr_word_i(wr_word),
    .wsel_i(wsel_in), .wdata_i(req_wdata_i), .wr_line_i(wr_line), .wline_i(fill_line));

  l1_spad_mem #(.WORDS(SPAD_WORDS), .DATA_W(DATA_W)) u_spad (
    .clk_i, .idx_i(req_addr_i[WB_LSB +: SP_IDX_W]), .we_i(spad_we),
    .wdata_i(req_wdata_i), .rdata_o(spad_rdata));

  assert_shared_keeps_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && space == SP_SHARED |=> valid_vec == $past(valid_vec));
  assert_shared_range_err_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && space == SP_SHARED && !in_range |=> rsp_valid_o && rsp_err_o);
  assert_global_no_alloc_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_BYP_W |=> valid_vec == $past(valid_vec));
  assert_global_inval_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && space == SP_GLOBAL && hit |=> !valid_vec[$past(idx_in)]);
  assert_rdonly_no_rsp_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && space == SP_RDONLY && !req_we_i |=> !rsp_valid_o);
  assert_busy_on_issue_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nl_req_valid_o |-> !req_ready_o);
  assert_global_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && space == SP_GLOBAL |=> !req_ready_o);
  assert_nl_rsp_forward_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_FILL_W || state_q == S_BYP_W) && nl_rsp_valid_i |=> rsp_valid_o && req_ready_o);
endmodule

// File: tb/tb_l1_space_ctrl.sv
module tb_l1_space_ctrl;
  localparam int AW = 32, DW = 32, LW = 1024, LWD = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, req_valid, req_we, req_ready_o, rsp_valid_o, rsp_err_o, ro_valid_o;
  logic [1:0] req_space;
  logic [AW-1:0] req_addr, ro_addr_o;
  logic [DW-1:0] req_wdata, rsp_rdata_o;
  logic nl_req_valid_o, nl_req_we_o, nl_rsp_valid;
  logic [AW-8:0] nl_req_line_o;
  logic [LWD-1:0] nl_req_wmask_o;
  logic [LW-1:0] nl_req_wdata_o, nl_rsp_rdata;

  l1_space_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready_o),
    .req_space_i(req_space), .req_we_i(req_we), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .rsp_valid_o(rsp_valid_o), .rsp_err_o(rsp_err_o),
    .rsp_rdata_o(rsp_rdata_o), .ro_valid_o(ro_valid_o), .ro_addr_o(ro_addr_o),
    .nl_req_valid_o(nl_req_valid_o), .nl_req_we_o(nl_req_we_o),
    .nl_req_line_o(nl_req_line_o), .nl_req_wmask_o(nl_req_wmask_o),
    .nl_req_wdata_o(nl_req_wdata_o), .nl_rsp_valid_i(nl_rsp_valid),
    .nl_rsp_rdata_i(nl_rsp_rdata));

  int n_cmp = 0, n_bad = 0;
  logic [DW-1:0] exp_d_q[$];
  logic          exp_e_q[$];
  string         exp_t_q[$];

  task automatic check(input string r, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  // next-level memory model
  logic [LW-1:0] mem [logic [24:0]];
  int nl_rd = 0, nl_wr = 0;
  logic [LWD-1:0] last_mask;
  logic [LW-1:0]  last_wdata;

  function automatic logic [DW-1:0] init_word(input logic [24:0] l, input int w);
    return 32'h5A5A_0000 ^ ((32'(l) << 5) | 32'(w));
  endfunction

  function automatic logic [LW-1:0] get_line(input logic [24:0] l);
    logic [LW-1:0] v;
    if (mem.exists(l)) return mem[l];
    for (int w = 0; w < LWD; w++) v[w*DW +: DW] = init_word(l, w);
    return v;
  endfunction

  initial begin
    nl_rsp_valid = 1'b0;
    nl_rsp_rdata = '0;
    forever begin
      @(negedge clk);
      nl_rsp_valid = 1'b0;
      if (rst_n && nl_req_valid_o) begin
        logic [24:0] l;
        logic [LW-1:0] v;
        l = nl_req_line_o;
        v = get_line(l);
        if (nl_req_we_o) begin
          nl_wr++;
          last_mask  = nl_req_wmask_o;
          last_wdata = nl_req_wdata_o;
          for (int w = 0; w < LWD; w++)
            if (nl_req_wmask_o[w]) v[w*DW +: DW] = nl_req_wdata_o[w*DW +: DW];
          mem[l] = v;
        end else nl_rd++;
        repeat (2) @(negedge clk);
        nl_rsp_rdata = v;
        nl_rsp_valid = 1'b1;
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid_o) begin
      if (exp_d_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R8 unexpected response: actual %h expected none", rsp_rdata_o);
      end else begin
        string t;
        logic [DW-1:0] d;
        logic e;
        t = exp_t_q.pop_front(); d = exp_d_q.pop_front(); e = exp_e_q.pop_front();
        check({t, " data"}, rsp_rdata_o, d);
        check({t, " err"}, 32'(rsp_err_o), 32'(e));
      end
    end
  end

  task automatic run(input string r, input logic [1:0] sp, input logic we,
                     input logic [AW-1:0] a, input logic [DW-1:0] wd, input bit has_rsp,
                     input logic [DW-1:0] ed, input logic ee, input bit busy);
    @(negedge clk);
    while (!req_ready_o) @(negedge clk);
    if (has_rsp) begin exp_t_q.push_back(r); exp_d_q.push_back(ed); exp_e_q.push_back(ee); end
    req_valid = 1'b1; req_space = sp; req_we = we; req_addr = a; req_wdata = wd;
    #1;
    if (sp == 2'd3 && !we) begin
      check({r, " ro_valid"}, 32'(ro_valid_o), 32'd1);
      check({r, " ro_addr"}, ro_addr_o, a);
    end
    @(posedge clk);
    #1 req_valid = 1'b0;
    @(negedge clk);
    check({r, " R9 ready"}, 32'(req_ready_o), 32'(!busy));
    while (exp_d_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  int rd0, wr0;
  task automatic snap(); rd0 = nl_rd; wr0 = nl_wr; endtask
  task automatic nl_delta(input string r, input int drd, input int dwr);
    check({r, " nl reads"}, 32'(nl_rd - rd0), 32'(drd));
    check({r, " nl writes"}, 32'(nl_wr - wr0), 32'(dwr));
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_space = '0; req_we = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    check("R10 ready", 32'(req_ready_o), 32'd1);
    check("R10 rsp_valid", 32'(rsp_valid_o), 32'd0);
    check("R10 nl_valid", 32'(nl_req_valid_o), 32'd0);
    rst_n = 1'b1;

    // R1 scratchpad
    snap();
    run("R1 wr", 2'd0, 1, 32'h10, 32'h1111_2222, 1, 32'h0, 0, 0);
    run("R1 wr top", 2'd0, 1, 32'hFC, 32'hABCD_0001, 1, 32'h0, 0, 0);
    run("R1 rd", 2'd0, 0, 32'h10, 32'h0, 1, 32'h1111_2222, 0, 0);
    run("R1 rd top", 2'd0, 0, 32'hFC, 32'h0, 1, 32'hABCD_0001, 0, 0);
    nl_delta("R1", 0, 0);
    // R3 out of range
    run("R3 rd", 2'd0, 0, 32'h100, 32'h0, 1, 32'h0, 1, 0);
    run("R3 wr", 2'd0, 1, 32'h104, 32'h55, 1, 32'h0, 1, 0);

    // R4 local miss then hit (R10: first access misses)
    snap();
    run("R4 miss", 2'd1, 0, 32'h1000_0084, 0, 1, init_word(25'h200001, 1), 0, 1);
    nl_delta("R4 miss", 1, 0);
    snap();
    run("R4 hit", 2'd1, 0, 32'h1000_0094, 0, 1, init_word(25'h200001, 5), 0, 0);
    nl_delta("R4 hit", 0, 0);

    // R2 shared access at same index does not disturb lines
    run("R2 sh wr", 2'd0, 1, 32'h84, 32'h9999, 1, 32'h0, 0, 0);
    snap();
    run("R2 hit", 2'd1, 0, 32'h1000_0084, 0, 1, init_word(25'h200001, 1), 0, 0);
    nl_delta("R2", 0, 0);

    // R5 dirty eviction
    run("R5 st", 2'd1, 1, 32'h1000_0088, 32'hDEAD_BEEF, 1, 32'h0, 0, 0);
    run("R5 ld", 2'd1, 0, 32'h1000_0088, 0, 1, 32'hDEAD_BEEF, 0, 0);
    snap();
    run("R5 evict", 2'd1, 0, 32'h2000_0084, 0, 1, init_word(25'h400001, 1), 0, 1);
    nl_delta("R5 evict", 1, 1);
    check("R5 wb mask", last_mask, 32'hFFFF_FFFF);
    check("R5 wb word2", mem[25'h200001][2*DW +: DW], 32'hDEAD_BEEF);
    check("R5 wb word1", mem[25'h200001][1*DW +: DW], init_word(25'h200001, 1));
    snap();
    run("R5 refill", 2'd1, 0, 32'h1000_0088, 0, 1, 32'hDEAD_BEEF, 0, 1);
    nl_delta("R5 refill", 1, 0);

    // R6/R7 global load hits cached line: bypass, invalidate, no allocate
    snap();
    run("R7 gld", 2'd2, 0, 32'h1000_0090, 0, 1, init_word(25'h200001, 4), 0, 1);
    run("R6 gld again", 2'd2, 0, 32'h1000_0090, 0, 1, init_word(25'h200001, 4), 0, 1);
    nl_delta("R6 gld", 2, 0);
    snap();
    run("R7 local miss", 2'd1, 0, 32'h1000_0088, 0, 1, 32'hDEAD_BEEF, 0, 1);
    nl_delta("R7 local miss", 1, 0);

    // R6 global store single-word mask
    snap();
    run("R6 gst", 2'd2, 1, 32'h3000_0100, 32'h1234_5678, 1, 32'h0, 0, 1);
    nl_delta("R6 gst", 0, 1);
    check("R6 mask", last_mask, 32'h0000_0001);
    check("R6 slot", last_wdata[0 +: DW], 32'h1234_5678);
    run("R6 gld back", 2'd2, 0, 32'h3000_0100, 0, 1, 32'h1234_5678, 0, 1);

    // R7 global store invalidates a dirty line, dirty data discarded
    run("R7 dirty st", 2'd1, 1, 32'h1000_0088, 32'h0000_CAFE, 1, 32'h0, 0, 0);
    snap();
    run("R7 gst", 2'd2, 1, 32'h1000_008C, 32'h77, 1, 32'h0, 0, 1);
    check("R7 gst mask", last_mask, 32'h0000_0008);
    run("R7 reload", 2'd1, 0, 32'h1000_0088, 0, 1, 32'hDEAD_BEEF, 0, 1);
    nl_delta("R7 no wb", 1, 1);
    run("R7 word3", 2'd1, 0, 32'h1000_008C, 0, 1, 32'h77, 0, 0);

    // R8 read-only port
    snap();
    run("R8 ro ld", 2'd3, 0, 32'h5000_0040, 0, 0, 0, 0, 0);
    nl_delta("R8", 0, 0);
    run("R8 ro st", 2'd3, 1, 32'h5000_0040, 32'h1, 1, 32'h0, 1, 0);

    repeat (5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule